// File: doc/BRIEF.md
# Privilege and Interrupt Control Unit

This unit holds the privilege state of a small multithreaded core: whether the core runs in supervisor mode, whether external interrupts are enabled, and the address where interrupt handling begins. Each cycle the core may offer one decoded instruction, given as a class code with one register operand. The unit acts on the classes it owns. It blocks privileged classes issued from user mode, raises traps, and delivers external interrupt requests. Its answers are a PC redirect, an interrupt cause, and a thread-count restore for the core.

When any interrupt is taken, the unit copies the current PC, the mode, the enable flag and the active-thread count into a shadow context. It then enters supervisor mode with interrupts disabled and steers the PC to the entry address. A return-from-interrupt puts the shadow context back. It restores mode and enable directly, sends the PC out as a redirect, and sends the thread count out as a restore pulse.

The instruction input is a valid/ready stream. `instr_ready` is low in any cycle where an external request is pending while interrupts are enabled. That cycle is given to the interrupt, and the offered instruction is not consumed, so the core must hold it or offer it again. All result outputs are registered one-cycle pulses and cannot be stalled.

Top module: `priv_irq_ctrl`

## Requirements
- R1: After reset the unit is in supervisor mode, interrupts are disabled, the entry address is 0, no pulse output is active, and `instr_ready` is high.
- R2: Class codes are 0 none, 1 disable-interrupts, 2 enable-interrupts, 3 trap, 4 return-from-interrupt, 5 set-entry, 6 user-jump, 7 other privileged operation. Classes 1, 2, 4, 5, 6 and 7 are privileged. A privileged instruction accepted in user mode does not execute and takes an interrupt with cause 3.
- R3: An accepted trap (class 3) takes an interrupt with cause 0 in either mode.
- R4: In supervisor mode, disable-interrupts clears the enable flag and enable-interrupts sets it, visible on `irq_enable` after the accepting edge.
- R5: In supervisor mode, user-jump clears supervisor mode and, in the next cycle, pulses `redirect_valid` with `redirect_pc` equal to the operand.
- R6: In supervisor mode, set-entry loads the operand as the entry address. Every later interrupt redirects there.
- R7: Taking an interrupt saves PC, mode, enable flag and `active_threads`. It sets supervisor mode, clears the enable flag, and in the next cycle pulses `cause_valid` and `redirect_valid`, with the cause on `cause_code` and the entry address on `redirect_pc`.
- R8: An external request is taken only while the enable flag is set, with cause `irq_cause`. `instr_ready` is low exactly in those cycles.
- R9: Return-from-interrupt in supervisor mode restores mode and enable flag from the shadow copy. In the next cycle it pulses `redirect_valid` with the saved PC and `restore_valid` with the saved thread count.
- R10: When no event occurs, no pulse output is active. Each pulse lasts one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction class is offered |
| instr_ready | output | 1 | The offered instruction is consumed this cycle |
| instr_class | input | 3 | Instruction class code (see R2) |
| operand | input | XLEN | Register operand of the instruction |
| cur_pc | input | XLEN | PC to be saved if an interrupt is taken |
| active_threads | input | TW | Current active-thread count |
| irq_req | input | 1 | External interrupt request |
| irq_cause | input | CW | Cause code of the external request |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | XLEN | Redirect target |
| cause_valid | output | 1 | Interrupt-taken pulse |
| cause_code | output | CW | Cause of the taken interrupt |
| restore_valid | output | 1 | Thread-count restore pulse |
| restore_threads | output | TW | Thread count restored from the shadow copy |
| supervisor | output | 1 | Supervisor mode flag |
| irq_enable | output | 1 | Interrupt enable flag |

## Verification
The hardest case to reach is a return-from-interrupt whose restored state differs from the state before the interrupt. The round trip must leave the core in user mode with interrupts enabled, so the stimulus has to walk a full path first: enable interrupts, set an entry, user-jump, issue a privileged class from user mode, then return. A directed sequence walks this path, and an external request in the same cycle as a privileged instruction checks which one wins. Long random runs then mix all classes, modes and requests, and a bench model tracks the shadow context.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_DI     = 3'd1,
    CLS_EI     = 3'd2,
    CLS_TRAP   = 3'd3,
    CLS_RETI   = 3'd4,
    CLS_SETENT = 3'd5,
    CLS_UJMP   = 3'd6,
    CLS_PRIVOP = 3'd7
  } icls_e;

  function automatic logic cls_is_priv(icls_e c);
    return (c != CLS_NONE) && (c != CLS_TRAP);
  endfunction
endpackage

// File: rtl/pic_decode.sv
module pic_decode
  import pic_pkg::*;
#(
  parameter int CW         = 4,
  parameter int PRIV_CAUSE = 3,
  parameter int TRAP_CAUSE = 0
) (
  input  logic          instr_valid,
  input  icls_e         cls,
  input  logic          sup,
  input  logic          ie,
  input  logic          irq_req,
  input  logic [CW-1:0] irq_cause,
  output logic          ready,
  output logic          take,
  output logic [CW-1:0] take_cause,
  output logic          do_di,
  output logic          do_ei,
  output logic          do_setent,
  output logic          do_ujmp,
  output logic          do_reti
);
  logic ext, fire, viol, trap, legal;

  always_comb begin
    ext   = irq_req && ie;
    ready = !ext;
    fire  = instr_valid && ready;
    viol  = fire && !sup && cls_is_priv(cls);
    trap  = fire && (cls == CLS_TRAP);
    take  = ext || viol || trap;
    if (ext)       take_cause = irq_cause;
    else if (trap) take_cause = CW'(TRAP_CAUSE);
    else           take_cause = CW'(PRIV_CAUSE);
    legal     = fire && sup;
    do_di     = legal && (cls == CLS_DI);
    do_ei     = legal && (cls == CLS_EI);
    do_setent = legal && (cls == CLS_SETENT);
    do_ujmp   = legal && (cls == CLS_UJMP);
    do_reti   = legal && (cls == CLS_RETI);
  end
endmodule

// File: rtl/pic_shadow.sv
module pic_shadow #(
  parameter int XLEN = 32,
  parameter int TW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save,
  input  logic [XLEN-1:0] pc_in,
  input  logic            sup_in,
  input  logic            ie_in,
  input  logic [TW-1:0]   thr_in,
  output logic [XLEN-1:0] pc_q,
  output logic            sup_q,
  output logic            ie_q,
  output logic [TW-1:0]   thr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sup_q <= 1'b1;
      ie_q  <= 1'b0;
      thr_q <= '0;
    end else if (save) begin
      pc_q  <= pc_in;
      sup_q <= sup_in;
      ie_q  <= ie_in;
      thr_q <= thr_in;
    end
  end
endmodule

// File: rtl/pic_mode.sv
module pic_mode #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            do_di,
  input  logic            do_ei,
  input  logic            do_setent,
  input  logic            do_ujmp,
  input  logic            do_reti,
  input  logic [XLEN-1:0] operand,
  input  logic            sh_sup,
  input  logic            sh_ie,
  output logic            sup_q,
  output logic            ie_q,
  output logic [XLEN-1:0] entry_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q   <= 1'b1;
      ie_q    <= 1'b0;
      entry_q <= '0;
    end else begin
      if (take) begin
        sup_q <= 1'b1;
        ie_q  <= 1'b0;
      end else if (do_ujmp) begin
        sup_q <= 1'b0;
      end else if (do_reti) begin
        sup_q <= sh_sup;
        ie_q  <= sh_ie;
      end else if (do_di) begin
        ie_q <= 1'b0;
      end else if (do_ei) begin
        ie_q <= 1'b1;
      end
      if (do_setent) entry_q <= operand;
    end
  end
endmodule

// File: rtl/priv_irq_ctrl.sv
module priv_irq_ctrl
  import pic_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int TW         = 4,
  parameter int CW         = 4,
  parameter int PRIV_CAUSE = 3,
  parameter int TRAP_CAUSE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [2:0]      instr_class,
  input  logic [XLEN-1:0] operand,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [TW-1:0]   active_threads,
  input  logic            irq_req,
  input  logic [CW-1:0]   irq_cause,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            cause_valid,
  output logic [CW-1:0]   cause_code,
  output logic            restore_valid,
  output logic [TW-1:0]   restore_threads,
  output logic            supervisor,
  output logic            irq_enable
);
  logic            take, do_di, do_ei, do_setent, do_ujmp, do_reti;
  logic [CW-1:0]   take_cause;
  logic            sup_q, ie_q, sh_sup, sh_ie;
  logic [XLEN-1:0] entry_q, sh_pc;
  logic [TW-1:0]   sh_thr;

  pic_decode #(.CW(CW), .PRIV_CAUSE(PRIV_CAUSE), .TRAP_CAUSE(TRAP_CAUSE)) u_dec (
    .instr_valid(instr_valid), .cls(icls_e'(instr_class)), .sup(sup_q), .ie(ie_q),
    .irq_req(irq_req), .irq_cause(irq_cause), .ready(instr_ready), .take(take),
    .take_cause(take_cause), .do_di(do_di), .do_ei(do_ei), .do_setent(do_setent),
    .do_ujmp(do_ujmp), .do_reti(do_reti)
  );

  pic_shadow #(.XLEN(XLEN), .TW(TW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .save(take), .pc_in(cur_pc), .sup_in(sup_q),
    .ie_in(ie_q), .thr_in(active_threads), .pc_q(sh_pc), .sup_q(sh_sup),
    .ie_q(sh_ie), .thr_q(sh_thr)
  );

  pic_mode #(.XLEN(XLEN)) u_mode (
    .clk(clk), .rst_n(rst_n), .take(take), .do_di(do_di), .do_ei(do_ei),
    .do_setent(do_setent), .do_ujmp(do_ujmp), .do_reti(do_reti),
    .operand(operand), .sh_sup(sh_sup), .sh_ie(sh_ie), .sup_q(sup_q),
    .ie_q(ie_q), .entry_q(entry_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid  <= 1'b0;
      redirect_pc     <= '0;
      cause_valid     <= 1'b0;
      cause_code      <= '0;
      restore_valid   <= 1'b0;
      restore_threads <= '0;
    end else begin
      redirect_valid <= take || do_ujmp || do_reti;
      cause_valid    <= take;
      restore_valid  <= do_reti;
      if (take)          redirect_pc <= entry_q;
      else if (do_ujmp)  redirect_pc <= operand;
      else if (do_reti)  redirect_pc <= sh_pc;
      if (take)          cause_code <= take_cause;
      if (do_reti)       restore_threads <= sh_thr;
    end
  end

  assign supervisor = sup_q;
  assign irq_enable = ie_q;
endmodule

// File: rtl/priv_irq_ctrl_chk.sv
module priv_irq_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic            instr_ready,
  input logic [2:0]      instr_class,
  input logic [XLEN-1:0] operand,
  input logic            irq_req,
  input logic [CW-1:0]   irq_cause,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            cause_valid,
  input logic [CW-1:0]   cause_code,
  input logic            supervisor,
  input logic            irq_enable
);
  logic acc;
  assign acc = instr_valid && instr_ready;

  assert_trap_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && instr_class == 3'd3 |=> cause_valid && cause_code == CW'(0));

  assert_user_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !supervisor && instr_class != 3'd0 && instr_class != 3'd3
    |=> cause_valid && cause_code == CW'(3) && supervisor);

  assert_take_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> supervisor && !irq_enable && redirect_valid);

  assert_ujmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && supervisor && instr_class == 3'd6
    |=> !supervisor && redirect_valid && redirect_pc == $past(operand));

  assert_ext_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_enable |=> cause_valid && cause_code == $past(irq_cause));

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> instr_ready);
endmodule

bind priv_irq_ctrl priv_irq_ctrl_chk #(.XLEN(XLEN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_class(instr_class), .operand(operand), .irq_req(irq_req),
  .irq_cause(irq_cause), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .cause_valid(cause_valid), .cause_code(cause_code), .supervisor(supervisor),
  .irq_enable(irq_enable)
);

// File: tb/priv_irq_ctrl_tb.sv
module priv_irq_ctrl_tb;
  localparam int XLEN = 32, TW = 4, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, irq_req = 1'b0;
  logic [2:0] instr_class = 3'd0;
  logic [XLEN-1:0] operand = '0, cur_pc = '0;
  logic [TW-1:0] active_threads = '0;
  logic [CW-1:0] irq_cause = '0;
  logic instr_ready, redirect_valid, cause_valid, restore_valid, supervisor, irq_enable;
  logic [XLEN-1:0] redirect_pc;
  logic [CW-1:0] cause_code;
  logic [TW-1:0] restore_threads;

  always #10 clk = ~clk;

  priv_irq_ctrl #(.XLEN(XLEN), .TW(TW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_class(instr_class), .operand(operand), .cur_pc(cur_pc),
    .active_threads(active_threads), .irq_req(irq_req), .irq_cause(irq_cause),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .cause_valid(cause_valid), .cause_code(cause_code), .restore_valid(restore_valid),
    .restore_threads(restore_threads), .supervisor(supervisor), .irq_enable(irq_enable)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  bit m_sup, m_ie, m_ssup, m_sie;
  logic [XLEN-1:0] m_entry, m_spc;
  logic [TW-1:0] m_sthr;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_priv(logic [2:0] c);
    return c != 3'd0 && c != 3'd3;
  endfunction

  // one cycle: inputs driven at negedge, outputs checked at the next negedge
  task automatic step(bit v, logic [2:0] c, logic [XLEN-1:0] op, logic [XLEN-1:0] pc,
                      logic [TW-1:0] thr, bit irq, logic [CW-1:0] ic);
    bit ext, fire, viol, trp, take, e_rv, e_cv, e_tv;
    logic [XLEN-1:0] e_rpc;
    logic [CW-1:0] e_cc;
    logic [TW-1:0] e_tval;
    string tag;
    instr_valid = v; instr_class = c; operand = op; cur_pc = pc;
    active_threads = thr; irq_req = irq; irq_cause = ic;
    ext = irq && m_ie;
    #1;
    chk(instr_ready == !ext, "R8", "instr_ready", instr_ready, !ext);
    fire = v && !ext;
    viol = fire && !m_sup && is_priv(c);
    trp  = fire && c == 3'd3;
    take = ext || viol || trp;
    e_rv = 0; e_cv = 0; e_tv = 0; e_rpc = '0; e_cc = '0; e_tval = '0; tag = "R10";
    if (take) begin
      tag = ext ? "R8" : (trp ? "R3" : "R2");
      e_cv = 1; e_rv = 1; e_rpc = m_entry;
      e_cc = ext ? ic : (trp ? CW'(0) : CW'(3));
      m_spc = pc; m_ssup = m_sup; m_sie = m_ie; m_sthr = thr;
      m_sup = 1; m_ie = 0;
    end else if (fire && m_sup) begin
      case (c)
        3'd1: begin m_ie = 0; tag = "R4"; end
        3'd2: begin m_ie = 1; tag = "R4"; end
        3'd5: begin m_entry = op; tag = "R6"; end
        3'd6: begin m_sup = 0; e_rv = 1; e_rpc = op; tag = "R5"; end
        3'd4: begin
          e_rv = 1; e_rpc = m_spc; e_tv = 1; e_tval = m_sthr;
          m_sup = m_ssup; m_ie = m_sie; tag = "R9";
        end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk(redirect_valid == e_rv, tag, "redirect_valid", redirect_valid, e_rv);
    if (e_rv) chk(redirect_pc == e_rpc, tag, "redirect_pc", redirect_pc, e_rpc);
    chk(cause_valid == e_cv, tag, "cause_valid", cause_valid, e_cv);
    if (e_cv) chk(cause_code == e_cc, tag, "cause_code", cause_code, e_cc);
    chk(restore_valid == e_tv, tag, "restore_valid", restore_valid, e_tv);
    if (e_tv) chk(restore_threads == e_tval, tag, "restore_threads", restore_threads, e_tval);
    if (take) tag = "R7";
    chk(supervisor == m_sup, tag, "supervisor", supervisor, m_sup);
    chk(irq_enable == m_ie, tag, "irq_enable", irq_enable, m_ie);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EED_0017;
    void'($urandom(seed));
    m_sup = 1; m_ie = 0; m_entry = '0; m_spc = '0; m_ssup = 1; m_sie = 0; m_sthr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(supervisor == 1, "R1", "supervisor", supervisor, 1);
    chk(irq_enable == 0, "R1", "irq_enable", irq_enable, 0);
    chk(!redirect_valid && !cause_valid && !restore_valid, "R1", "pulses", 0, 0);
    chk(instr_ready == 1, "R1", "instr_ready", instr_ready, 1);
    @(negedge clk);
    // R1/R3: trap right after reset goes to entry 0
    step(1, 3'd3, 32'h0, 32'h100, 4'd2, 0, 4'h0);
    // R8: request ignored while disabled
    step(0, 3'd0, 32'h0, 32'h104, 4'd2, 1, 4'h9);
    step(1, 3'd2, 32'h0, 32'h108, 4'd2, 0, 4'h0);        // R4 enable
    step(1, 3'd5, 32'h400, 32'h10c, 4'd2, 0, 4'h0);      // R6 entry
    step(1, 3'd6, 32'h2000, 32'h110, 4'd3, 0, 4'h0);     // R5 user jump
    step(1, 3'd1, 32'h0, 32'h2000, 4'd3, 0, 4'h0);       // R2 di in user -> cause 3
    step(1, 3'd4, 32'h0, 32'h400, 4'd1, 0, 4'h0);        // R9 back to user, ie=1
    step(1, 3'd7, 32'h0, 32'h2004, 4'd5, 1, 4'hA);       // R8 request beats instruction
    step(1, 3'd4, 32'h0, 32'h400, 4'd1, 0, 4'h0);        // R9
    step(1, 3'd0, 32'h0, 32'h2004, 4'd5, 0, 4'h0);       // R10 nothing
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, 3'($urandom % 8), $urandom, $urandom,
           TW'($urandom), ($urandom % 8) == 0, CW'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule